// File: doc/BRIEF.md
# UART Command Decoder and Interrupt Controller

This block sits on the register side of a serial port. A write to its command word turns into single-cycle action strobes for the receive and transmit paths, updates the enable state of both directions and of stale-event detection, and can clear individual latched interrupt causes. The command word carries three kinds of information: four direction-enable bits, a five-bit channel command and a three-bit general command.

The block collects event pulses from the transmit and receive paths and the clear-to-send level. Most causes latch until a specific command clears them. A few causes simply follow their input level. A mask register selects which causes reach the masked status view, and the single interrupt line is a registered OR of that view. The raw status, masked status and mask are all visible on output ports for a read mux outside the block.

Top module: `uart_cmd_irq`

## Requirements
- R1: Command bit 0 enables RX, bit 1 disables RX, bit 2 enables TX and bit 3 disables TX, taking effect at the write edge. A disable bit wins over an enable bit written in the same word. Both directions are disabled after reset.
- R2: The channel command is the 5-bit value {cmd_data[11], cmd_data[7:4]}. Codes 1 (reset RX), 2 (reset TX), 3 (reset error status), 5 (start break) and 6 (stop break) each raise their own strobe for exactly the one cycle after the write edge. No other code raises any strobe.
- R3: Channel codes clear exactly one latched cause each: 4 clears bit 2, 7 clears bit 5, 8 clears bit 3, 0x10 clears bit 8, 0x11 clears bit 9, 0x12 clears bit 10, 0x13 clears bit 11 and 0x14 clears bit 12.
- R4: The general command is cmd_data[10:8]. Code 3 clears bit 7, code 4 sets bit 3 unconditionally, code 5 enables stale events and code 6 disables them. Stale events are disabled after reset.
- R5: An RX stale pulse sets bit 3 only while stale events are enabled.
- R6: The latched causes are bit 2 (break change), bit 3 (RX stale), bit 5 (CTS change), bit 7 (TX ready), bit 8 (TX error), bit 9 (TX done), bit 10 (break start), bit 11 (break end) and bit 12 (parity or framing error). Each sets on its event pulse and holds until its clearing command.
- R7: When an event and its clearing command land in the same cycle, the cause ends up set.
- R8: Bits 0 (TX level), 1 (RX hunt), 4 (RX level) and 6 (current CTS) follow their input levels with one register of delay. Bit 5 sets whenever cts_in differs from its value one cycle earlier.
- R9: A write to the mask port loads all 13 mask bits, and the masked status equals the raw status ANDed with the mask.
- R10: irq equals the OR of the masked status one cycle earlier.
- R11: Reset clears all status, the mask, every strobe and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 12 | Command word |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 13 | New mask value |
| tx_level_in | input | 1 | TX FIFO at or below watermark (level) |
| rx_hunt_in | input | 1 | Hunt character seen (level) |
| rx_level_in | input | 1 | RX FIFO above watermark (level) |
| cts_in | input | 1 | Clear-to-send, asserted high, synchronous |
| ev_brk_chg | input | 1 | Break-state change pulse |
| ev_rx_stale | input | 1 | RX stale timeout pulse |
| ev_tx_ready | input | 1 | TX transfer ready pulse |
| ev_tx_err | input | 1 | TX error pulse |
| ev_tx_done | input | 1 | TX done pulse |
| ev_brk_start | input | 1 | Break start pulse |
| ev_brk_end | input | 1 | Break end pulse |
| ev_par_frame | input | 1 | Parity or framing error pulse |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| stale_en | output | 1 | Stale events enabled |
| rx_reset_stb | output | 1 | Reset receiver strobe |
| tx_reset_stb | output | 1 | Reset transmitter strobe |
| err_reset_stb | output | 1 | Reset error status strobe |
| brk_start_stb | output | 1 | Start break strobe |
| brk_stop_stb | output | 1 | Stop break strobe |
| raw_status | output | 13 | Unmasked interrupt causes |
| masked_status | output | 13 | Causes ANDed with mask |
| mask_q | output | 13 | Current mask |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is an event pulse and the command that clears the same cause arriving on one clock edge; the bench drives each latched cause's event together with its own clearing code (and the CTS toggle with code 7) and requires the cause to read as set afterwards, then clears it alone and requires it to read as cleared. A second overlap is an enable and a disable bit in one command word, which the full sweep over all 4096 combinations of channel code, general code and direction bits covers, judged against a model of the enable state kept in the bench.

// File: rtl/uart_ci_pkg.sv
package uart_ci_pkg;

  localparam int unsigned NSRC  = 13;
  localparam int unsigned CMD_W = 12;
  localparam int unsigned CH_W  = 5;
  localparam int unsigned GEN_W = 3;

  // direction-enable bit positions in the command word
  localparam int unsigned C_RXEN  = 0;
  localparam int unsigned C_RXDIS = 1;
  localparam int unsigned C_TXEN  = 2;
  localparam int unsigned C_TXDIS = 3;

  // interrupt cause positions
  localparam int unsigned S_TXLEV  = 0;
  localparam int unsigned S_HUNT   = 1;
  localparam int unsigned S_BRKCHG = 2;
  localparam int unsigned S_STALE  = 3;
  localparam int unsigned S_RXLEV  = 4;
  localparam int unsigned S_CTSD   = 5;
  localparam int unsigned S_CTS    = 6;
  localparam int unsigned S_TXRDY  = 7;
  localparam int unsigned S_TXERR  = 8;
  localparam int unsigned S_TXDONE = 9;
  localparam int unsigned S_BRKS   = 10;
  localparam int unsigned S_BRKE   = 11;
  localparam int unsigned S_PARFR  = 12;

  localparam logic [NSRC-1:0] STICKY = (NSRC'(1) << S_BRKCHG) | (NSRC'(1) << S_STALE)
                                     | (NSRC'(1) << S_CTSD)   | (NSRC'(1) << S_TXRDY)
                                     | (NSRC'(1) << S_TXERR)  | (NSRC'(1) << S_TXDONE)
                                     | (NSRC'(1) << S_BRKS)   | (NSRC'(1) << S_BRKE)
                                     | (NSRC'(1) << S_PARFR);
  localparam logic [NSRC-1:0] LEVEL = ~STICKY;

  // general command codes
  localparam logic [GEN_W-1:0] G_CLR_TXRDY = 3'd3;
  localparam logic [GEN_W-1:0] G_FORCE     = 3'd4;
  localparam logic [GEN_W-1:0] G_STALE_ON  = 3'd5;
  localparam logic [GEN_W-1:0] G_STALE_OFF = 3'd6;

  typedef struct packed {
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic brk_on;
    logic brk_off;
  } strobe_t;

  function automatic logic [CH_W-1:0] chan_code(input logic [CMD_W-1:0] c);
    return {c[11], c[7:4]};
  endfunction

  function automatic logic [GEN_W-1:0] gen_code(input logic [CMD_W-1:0] c);
    return c[10:8];
  endfunction

  function automatic strobe_t decode_strobes(input logic [CH_W-1:0] ch);
    strobe_t s;
    s.rx_rst  = (ch == 5'd1);
    s.tx_rst  = (ch == 5'd2);
    s.err_rst = (ch == 5'd3);
    s.brk_on  = (ch == 5'd5);
    s.brk_off = (ch == 5'd6);
    return s;
  endfunction

  function automatic logic [NSRC-1:0] clear_vec(input logic [CH_W-1:0] ch,
                                                input logic [GEN_W-1:0] g);
    logic [NSRC-1:0] v;
    v = '0;
    case (ch)
      5'h04:   v[S_BRKCHG] = 1'b1;
      5'h07:   v[S_CTSD]   = 1'b1;
      5'h08:   v[S_STALE]  = 1'b1;
      5'h10:   v[S_TXERR]  = 1'b1;
      5'h11:   v[S_TXDONE] = 1'b1;
      5'h12:   v[S_BRKS]   = 1'b1;
      5'h13:   v[S_BRKE]   = 1'b1;
      5'h14:   v[S_PARFR]  = 1'b1;
      default: ;
    endcase
    if (g == G_CLR_TXRDY) v[S_TXRDY] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/uart_ci_cmd_dec.sv
module uart_ci_cmd_dec
  import uart_ci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             rx_en,
  output logic             tx_en,
  output logic             stale_en,
  output strobe_t          stb,
  output logic [NSRC-1:0]  clr_vec,
  output logic             force_stale
);

  logic [CH_W-1:0]  ch;
  logic [GEN_W-1:0] gc;

  assign ch          = chan_code(cmd_data);
  assign gc          = gen_code(cmd_data);
  assign clr_vec     = cmd_we ? clear_vec(ch, gc) : '0;
  assign force_stale = cmd_we && (gc == G_FORCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      stale_en <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= cmd_we ? decode_strobes(ch) : '0;
      if (cmd_we) begin
        if (cmd_data[C_RXDIS])     rx_en <= 1'b0;
        else if (cmd_data[C_RXEN]) rx_en <= 1'b1;
        if (cmd_data[C_TXDIS])     tx_en <= 1'b0;
        else if (cmd_data[C_TXEN]) tx_en <= 1'b1;
        if (gc == G_STALE_ON)       stale_en <= 1'b1;
        else if (gc == G_STALE_OFF) stale_en <= 1'b0;
      end
    end
  end

  p_rx_disable_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[C_RXDIS]) |=> !rx_en);
  p_tx_disable_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[C_TXDIS]) |=> !tx_en);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.rx_rst, stb.tx_rst, stb.err_rst, stb.brk_on, stb.brk_off}));
  p_strobe_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != '0) |-> $past(cmd_we));
  p_stale_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && gc == G_STALE_ON) |=> stale_en);

endmodule

// File: rtl/uart_ci_irq_bank.sv
module uart_ci_irq_bank
  import uart_ci_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] lvl_vec,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_data,
  output logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] masked,
  output logic [NSRC-1:0] mask_q,
  output logic            irq_q
);

  logic [NSRC-1:0] raw_d;
  logic            any_masked;

  // set is applied after clear, so a same-cycle event wins
  assign raw_d      = (STICKY & ((raw_q & ~clr_vec) | set_vec)) | (LEVEL & lvl_vec);
  assign masked     = raw_q & mask_q;
  assign any_masked = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      if (mask_we) mask_q <= mask_data;
      irq_q <= any_masked;
    end
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & STICKY)) |=> ((raw_q & $past(set_vec & STICKY)) == $past(set_vec & STICKY)));
  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec & STICKY)) |=> ((raw_q & $past(clr_vec & ~set_vec & STICKY)) == '0));
  p_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_q & STICKY)) |=> (($past(raw_q & ~clr_vec & STICKY) & ~raw_q) == '0));
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(|(raw_q & mask_q)));

endmodule

// File: rtl/uart_cmd_irq.sv
module uart_cmd_irq
  import uart_ci_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [11:0] cmd_data,
  input  logic        mask_we,
  input  logic [12:0] mask_data,
  input  logic        tx_level_in,
  input  logic        rx_hunt_in,
  input  logic        rx_level_in,
  input  logic        cts_in,
  input  logic        ev_brk_chg,
  input  logic        ev_rx_stale,
  input  logic        ev_tx_ready,
  input  logic        ev_tx_err,
  input  logic        ev_tx_done,
  input  logic        ev_brk_start,
  input  logic        ev_brk_end,
  input  logic        ev_par_frame,
  output logic        rx_en,
  output logic        tx_en,
  output logic        stale_en,
  output logic        rx_reset_stb,
  output logic        tx_reset_stb,
  output logic        err_reset_stb,
  output logic        brk_start_stb,
  output logic        brk_stop_stb,
  output logic [12:0] raw_status,
  output logic [12:0] masked_status,
  output logic [12:0] mask_q,
  output logic        irq
);

  strobe_t         stb;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] lvl_vec;
  logic            force_stale;
  logic            cts_q;
  logic            cts_delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_q <= 1'b0;
    else        cts_q <= cts_in;
  end

  assign cts_delta = cts_in ^ cts_q;

  always_comb begin
    set_vec           = '0;
    set_vec[S_BRKCHG] = ev_brk_chg;
    set_vec[S_STALE]  = (ev_rx_stale && stale_en) || force_stale;
    set_vec[S_CTSD]   = cts_delta;
    set_vec[S_TXRDY]  = ev_tx_ready;
    set_vec[S_TXERR]  = ev_tx_err;
    set_vec[S_TXDONE] = ev_tx_done;
    set_vec[S_BRKS]   = ev_brk_start;
    set_vec[S_BRKE]   = ev_brk_end;
    set_vec[S_PARFR]  = ev_par_frame;
    lvl_vec           = '0;
    lvl_vec[S_TXLEV]  = tx_level_in;
    lvl_vec[S_HUNT]   = rx_hunt_in;
    lvl_vec[S_RXLEV]  = rx_level_in;
    lvl_vec[S_CTS]    = cts_in;
  end

  uart_ci_cmd_dec u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_data    (cmd_data),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .stale_en    (stale_en),
    .stb         (stb),
    .clr_vec     (clr_vec),
    .force_stale (force_stale)
  );

  uart_ci_irq_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .lvl_vec   (lvl_vec),
    .mask_we   (mask_we),
    .mask_data (mask_data),
    .raw_q     (raw_status),
    .masked    (masked_status),
    .mask_q    (mask_q),
    .irq_q     (irq)
  );

  assign rx_reset_stb  = stb.rx_rst;
  assign tx_reset_stb  = stb.tx_rst;
  assign err_reset_stb = stb.err_rst;
  assign brk_start_stb = stb.brk_on;
  assign brk_stop_stb  = stb.brk_off;

  p_cts_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_in != cts_q) |=> raw_status[S_CTSD]);
  p_stale_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_status[S_STALE] && ev_rx_stale && !stale_en && !force_stale) |=> !raw_status[S_STALE]);

endmodule

// File: tb/sim_uart_cmd_irq.sv
`timescale 1ns/1ps
module sim_uart_cmd_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [11:0] cmd_data = '0;
  logic        mask_we = 1'b0;
  logic [12:0] mask_data = '0;
  logic        tx_level_in = 1'b0, rx_hunt_in = 1'b0, rx_level_in = 1'b0, cts_in = 1'b0;
  logic [12:0] ev = '0;
  logic        rx_en, tx_en, stale_en;
  logic        rx_reset_stb, tx_reset_stb, err_reset_stb, brk_start_stb, brk_stop_stb;
  logic [12:0] raw_status, masked_status, mask_q;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_cmd_irq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .mask_we(mask_we), .mask_data(mask_data),
    .tx_level_in(tx_level_in), .rx_hunt_in(rx_hunt_in), .rx_level_in(rx_level_in),
    .cts_in(cts_in),
    .ev_brk_chg(ev[2]), .ev_rx_stale(ev[3]), .ev_tx_ready(ev[7]), .ev_tx_err(ev[8]),
    .ev_tx_done(ev[9]), .ev_brk_start(ev[10]), .ev_brk_end(ev[11]), .ev_par_frame(ev[12]),
    .rx_en(rx_en), .tx_en(tx_en), .stale_en(stale_en),
    .rx_reset_stb(rx_reset_stb), .tx_reset_stb(tx_reset_stb), .err_reset_stb(err_reset_stb),
    .brk_start_stb(brk_start_stb), .brk_stop_stb(brk_stop_stb),
    .raw_status(raw_status), .masked_status(masked_status), .mask_q(mask_q), .irq(irq)
  );

  localparam logic [12:0] EV_ALL = 13'b1_1111_1000_1100;

  // bench-side model state
  logic [12:0] m;
  bit          m_rx, m_tx, m_stale;

  function automatic logic [11:0] mk(input int ch, input int g, input int en);
    logic [11:0] c;
    c = 12'(en & 15);
    c[7:4] = 4'(ch % 16);
    c[11]  = (ch >= 16);
    c[10:8] = 3'(g);
    return c;
  endfunction

  function automatic logic [12:0] bench_clr(input int ch, input int g);
    logic [12:0] r;
    r = '0;
    if (ch == 4)  r = r | 13'h0004;
    if (ch == 7)  r = r | 13'h0020;
    if (ch == 8)  r = r | 13'h0008;
    if (ch >= 16 && ch <= 20) r = r | (13'h0100 << (ch - 16));
    if (g == 3)   r = r | 13'h0080;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic write_cmd(input logic [11:0] c);
    cmd_we = 1'b1; cmd_data = c;
    cyc();
    cmd_we = 1'b0; cmd_data = '0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 32; c++) begin
      if (bench_clr(c, 0) != 0) write_cmd(mk(c, 0, 0));
    end
    write_cmd(mk(0, 3, 0));
    m = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m = '0; m_rx = 0; m_tx = 0; m_stale = 0;
    repeat (3) cyc();
    // R11: reset state
    chk("R11 status", {raw_status, mask_q}, '0);
    chk("R11 strobes/irq", {rx_reset_stb, tx_reset_stb, err_reset_stb, brk_start_stb, brk_stop_stb, irq}, '0);
    chk("R1 R4 reset enables", {rx_en, tx_en, stale_en}, '0);
    rst_n = 1'b1;
    cyc();

    // R1 R2 R3 R4 R5 R6: sweep of every channel, general and enable combination
    for (int ch = 0; ch < 32; ch++) begin
      for (int g = 0; g < 8; g++) begin
        for (int en = 0; en < 16; en++) begin
          ev = EV_ALL;
          cyc();
          ev = '0;
          m = m | (EV_ALL & ~(m_stale ? 13'h0 : 13'h0008));
          write_cmd(mk(ch, g, en));
          m = (m & ~bench_clr(ch, g)) | ((g == 4) ? 13'h0008 : 13'h0);
          if (en & 2) m_rx = 0; else if (en & 1) m_rx = 1;
          if (en & 8) m_tx = 0; else if (en & 4) m_tx = 1;
          if (g == 5) m_stale = 1; else if (g == 6) m_stale = 0;
          chk("R2 strobes", {rx_reset_stb, tx_reset_stb, err_reset_stb, brk_start_stb, brk_stop_stb},
              {27'd0, ch == 1, ch == 2, ch == 3, ch == 5, ch == 6});
          chk("R1 R4 enables", {rx_en, tx_en, stale_en}, {29'd0, m_rx, m_tx, m_stale});
          chk("R3 R6 raw", raw_status, m);
        end
      end
    end
    cyc();
    chk("R2 strobe one cycle", {rx_reset_stb, tx_reset_stb, err_reset_stb, brk_start_stb, brk_stop_stb}, '0);

    clear_all();
    chk("R3 all cleared", raw_status, '0);

    // R7: event and its clearing command in the same cycle
    write_cmd(mk(0, 5, 0));
    begin
      int bits [8] = '{2, 3, 7, 8, 9, 10, 11, 12};
      int chs  [8] = '{4, 8, 0, 16, 17, 18, 19, 20};
      int gs   [8] = '{0, 0, 3, 0, 0, 0, 0, 0};
      for (int k = 0; k < 8; k++) begin
        ev = 13'(1) << bits[k];
        write_cmd(mk(chs[k], gs[k], 0));
        ev = '0;
        chk($sformatf("R7 set wins bit %0d", bits[k]), raw_status, 13'(1) << bits[k]);
        write_cmd(mk(chs[k], gs[k], 0));
        chk($sformatf("R3 clear bit %0d", bits[k]), raw_status, '0);
      end
    end

    // R8: CTS level and change
    cts_in = 1'b1;
    cyc();
    chk("R8 cts rise", raw_status, 13'h0060);
    write_cmd(mk(7, 0, 0));
    chk("R8 cts delta cleared", raw_status, 13'h0040);
    cts_in = 1'b0;
    write_cmd(mk(7, 0, 0));
    chk("R7 cts change wins", raw_status, 13'h0020);
    write_cmd(mk(7, 0, 0));
    chk("R8 cts idle", raw_status, '0);

    // R8: level causes
    tx_level_in = 1'b1; rx_hunt_in = 1'b1; rx_level_in = 1'b1;
    cyc();
    chk("R8 levels high", raw_status, 13'h0013);
    tx_level_in = 1'b0; rx_hunt_in = 1'b0; rx_level_in = 1'b0;
    cyc();
    chk("R8 levels low", raw_status, '0);

    // R5 R4: stale gating and forcing
    write_cmd(mk(0, 6, 0));
    ev = 13'h0008;
    cyc();
    ev = '0;
    chk("R5 stale ignored when disabled", raw_status, '0);
    write_cmd(mk(0, 4, 0));
    chk("R4 forced stale", raw_status, 13'h0008);
    write_cmd(mk(8, 0, 0));
    chk("R3 stale cleared", raw_status, '0);

    // R9 R10: mask sweep with TX done latched
    ev = 13'h0200;
    cyc();
    ev = '0;
    for (int i = 0; i < 13; i++) begin
      mask_we = 1'b1; mask_data = 13'(1) << i;
      cyc();
      mask_we = 1'b0;
      chk("R9 mask", mask_q, 13'(1) << i);
      chk("R9 masked", masked_status, (i == 9) ? 13'h0200 : 13'h0);
      cyc();
      chk("R10 irq", irq, (i == 9) ? 1 : 0);
    end
    mask_we = 1'b1; mask_data = 13'h1FFF;
    cyc();
    mask_we = 1'b0;
    write_cmd(mk(17, 0, 0));
    chk("R9 masked after clear", masked_status, '0);
    chk("R10 irq lags", irq, 1);
    cyc();
    chk("R10 irq drops", irq, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule